// File: doc/BRIEF.md
# Saturating Descending Stack Pointer

This block keeps the pointer for a hardware stack that grows downward from the highest word of a data memory. On each cycle it takes a push request and a pop request. If either one is accepted, it puts the memory address for that access on its outputs in the same cycle, together with a write strobe or a read strobe. At the next clock edge it moves the pointer. The data memory and the register file are outside the block: the address and the strobes go straight to them.

A push uses the current pointer as the write address and then moves the pointer down by one. A pop uses the current pointer as the read address and then moves the pointer up by one. The pointer never goes above the stack base, which is the all-ones address. If a push is made while the pointer is at address zero, the pointer wraps to the base and an overflow flag is raised for one cycle. When push and pop arrive together, the push is served and the pop is dropped. The block does not check whether stack accesses collide with ordinary load or store addresses.

The request pins are plain level strobes. They have no handshake because the block accepts a request in every cycle. It applies no back-pressure and never stalls, so a caller does not need to wait before driving the next request.

Top module: `stack_ptr_sat`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the pointer equals the base address (all ones, 0x3FF for a 10-bit pointer), the overflow flag is 0, and both access strobes are 0 when no request is driven.
- R2: In a cycle with a push request, the access address equals the current pointer, the write strobe is 1 and the read strobe is 0. All of this appears in that same cycle, combinationally.
- R3: After a clock edge with a push request, the pointer equals its previous value minus one.
- R4: In a cycle with a pop request and no push request, the access address equals the current pointer, the read strobe is 1 and the write strobe is 0.
- R5: After a clock edge with a pop request (and no push) when the pointer is below the base, the pointer equals its previous value plus one.
- R6: A pop while the pointer equals the base leaves the pointer at the base and does not raise the overflow flag.
- R7: A push while the pointer is 0x000 wraps the pointer to the base. The overflow flag is then 1 for exactly the one cycle after that edge. In every other case the flag is 0.
- R8: When push and pop are requested in the same cycle, only the push is performed: only the write strobe is active, and the pointer decrements.
- R9: With no request, both strobes are 0 and the pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Request to store onto the stack this cycle |
| pop_req | input | 1 | Request to read from the stack this cycle |
| acc_addr | output | AW | Memory address for this cycle's stack access |
| acc_write | output | 1 | Write strobe for a push access |
| acc_read | output | 1 | Read strobe for a pop access |
| sp_q | output | AW | Current stack pointer |
| ovf_q | output | 1 | One-cycle pulse after a push wraps at address zero |

## Verification
The assertions take for granted that push_req and pop_req are known values that change only away from the rising edge. They also take for granted that reset is held for at least one edge, so that every `$past` value they use comes from a cycle after reset. The bench drives every input on the falling edge and keeps both requests low during reset. It first walks the pointer through every address with pushes, through the wrap, and back up with pops until saturation. It then applies a pseudo-random mix of push, pop, both and idle cycles.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic [1:0] {
    SP_IDLE = 2'd0,
    SP_PUSH = 2'd1,
    SP_POP  = 2'd2
  } sp_op_e;

endpackage

// File: rtl/sp_arb.sv
module sp_arb
  import sp_pkg::*;
#(
  parameter bit PUSH_WINS = 1'b1
) (
  input  logic   push_req,
  input  logic   pop_req,
  output sp_op_e op
);

  generate
    if (PUSH_WINS) begin : g_push_first
      always_comb begin
        if (push_req)     op = SP_PUSH;
        else if (pop_req) op = SP_POP;
        else              op = SP_IDLE;
      end
    end else begin : g_pop_first
      always_comb begin
        if (pop_req)       op = SP_POP;
        else if (push_req) op = SP_PUSH;
        else               op = SP_IDLE;
      end
    end
  endgenerate

endmodule

// File: rtl/sp_step.sv
module sp_step
  import sp_pkg::*;
#(
  parameter int AW = 10
) (
  input  sp_op_e        op,
  input  logic [AW-1:0] cur,
  output logic [AW-1:0] nxt,
  output logic          wrap
);

  localparam logic [AW-1:0] BASE = {AW{1'b1}};
  localparam logic [AW-1:0] FLOOR = '0;

  always_comb begin
    nxt  = cur;
    wrap = 1'b0;
    unique case (op)
      SP_PUSH: begin
        nxt  = cur - 1'b1;
        wrap = (cur == FLOOR);
      end
      SP_POP: begin
        if (cur != BASE) nxt = cur + 1'b1;
      end
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/stack_ptr_sat.sv
module stack_ptr_sat
  import sp_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  output logic [AW-1:0] acc_addr,
  output logic          acc_write,
  output logic          acc_read,
  output logic [AW-1:0] sp_q,
  output logic          ovf_q
);

  localparam logic [AW-1:0] BASE = {AW{1'b1}};

  sp_op_e        op;
  logic [AW-1:0] sp_d;
  logic          wrap;

  sp_arb #(.PUSH_WINS(1'b1)) u_arb (
    .push_req (push_req),
    .pop_req  (pop_req),
    .op       (op)
  );

  sp_step #(.AW(AW)) u_step (
    .op   (op),
    .cur  (sp_q),
    .nxt  (sp_d),
    .wrap (wrap)
  );

  // Each access uses the pointer before it moves
  assign acc_addr  = sp_q;
  assign acc_write = (op == SP_PUSH);
  assign acc_read  = (op == SP_POP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q  <= BASE;
      ovf_q <= 1'b0;
    end else begin
      sp_q  <= sp_d;
      ovf_q <= wrap;
    end
  end

  p_push_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |=> (sp_q == $past(sp_q) - 1'b1));

  p_pop_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && sp_q != BASE) |=> (sp_q == $past(sp_q) + 1'b1));

  p_base_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && sp_q == BASE) |=> (sp_q == BASE && !ovf_q));

  p_ovf_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> $past(push_req && sp_q == '0));

  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_write && acc_read));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_req && !pop_req) |=> $stable(sp_q));

endmodule

// File: tb/tb_stack_ptr_sat.sv
module tb_stack_ptr_sat;
  localparam int AW = 10;
  localparam logic [AW-1:0] BASE = {AW{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_req = 1'b0;
  logic pop_req = 1'b0;
  logic [AW-1:0] acc_addr, sp_q;
  logic acc_write, acc_read, ovf_q;

  int checks = 0;
  int failures = 0;
  logic [AW-1:0] m_sp;
  logic m_ovf;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  stack_ptr_sat #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
    .acc_addr(acc_addr), .acc_write(acc_write), .acc_read(acc_read),
    .sp_q(sp_q), .ovf_q(ovf_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, check strobes, then check state after edge
  task automatic step(input logic pu, input logic po);
    @(negedge clk);
    push_req = pu;
    pop_req  = po;
    #1;
    chk(pu ? "R2 addr" : (po ? "R4 addr" : "R9 addr"), acc_addr, m_sp);
    chk(pu ? "R2/R8 write" : "R4/R9 write", acc_write, pu);
    chk(pu ? "R8 read" : "R4/R9 read", acc_read, !pu && po);
    if (pu) begin
      m_ovf = (m_sp == '0);
      m_sp  = m_sp - 1'b1;
    end else begin
      m_ovf = 1'b0;
      if (po && m_sp != BASE) m_sp = m_sp + 1'b1;
    end
    @(posedge clk);
    #1;
    chk(pu ? "R3 ptr" : (po ? "R5/R6 ptr" : "R9 ptr"), sp_q, m_sp);
    chk("R7 ovf", ovf_q, m_ovf);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset ptr", sp_q, BASE);
    chk("R1 reset ovf", ovf_q, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 first ptr", sp_q, BASE);
    chk("R1 strobes", {acc_write, acc_read}, 2'b00);
    m_sp = BASE;
    m_ovf = 1'b0;
    // R6: pop at base saturates
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    // Sweep down through every address and across the wrap (R3, R7)
    for (int i = 0; i < (1 << AW) + 2; i++) step(1'b1, 1'b0);
    // Back up to saturation and beyond (R5, R6)
    for (int i = 0; i < (1 << AW) + 4; i++) step(1'b0, 1'b1);
    // R8 simultaneous and R9 idle
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    // Mixed pattern
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[3], lfsr[1]);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule